// File: doc/BRIEF.md
# Predetermining BCD Up/Down Counter

This block is a six-decade synchronous BCD counter. It steps once for every qualified rising edge of an external count strobe. The strobe is first brought into the system clock domain and edge-detected. It then passes through a selectable prescaler that divides by 5, 6 or 1. The direction input chooses between counting up and counting down.

Three comparators watch the value that each step lands on. One compares it against a presignal store, one against a main-signal store, and one against zero. When counting up and the main-signal value is reached, the counter can clear itself to zero. When counting down and zero is reached, it can reload itself from the preset store. Each of these automatic reloads can be disabled on its own, so that the count waits for a manual action. Manual clear and manual load inputs override all counting.

Top module: `bcd_predet_counter`

## Requirements
- R1: Every 4-bit digit of `count_o` is always in 0..9. Counting up, a digit wraps from 9 to 0 and carries into the next digit. Counting down, a digit wraps from 0 to 9 and borrows. 999999+1 gives 000000 and 000000-1 gives 999999.
- R2: With `up_dn`=1 each prescaler output step adds one to the count. With `up_dn`=0 each step subtracts one. A strobe rise appears on `count_o` three clock edges after the first edge that samples `cnt_in` high.
- R3: `div_sel` sets the number of strobe rises per step: 2'b00 gives 5, 2'b01 gives 6, and 2'b11 or 2'b10 gives 1. The prescaler phase returns to zero on `clr` or `load`.
- R4: While `cnt_hold`=1, strobe rises are discarded and `count_o` does not change.
- R5: `clr`=1 sets the count to 000000 on the next edge and clears `main_flag` and `presig_flag`. `clr` takes priority over `load`.
- R6: `load`=1 (with `clr`=0) copies `preset_val` into the count on the next edge and clears `presig_flag`. `load` takes priority over `cnt_hold`.
- R7: With `up_dn`=1 and `no_auto_clr`=0, a step that lands on `main_val` leaves the count at 000000 and raises `main_flag` for exactly one clock.
- R8: With `no_auto_clr`=1, a step that lands on `main_val` keeps that value and holds `main_flag` high until the next step or `clr`.
- R9: With `up_dn`=0 and `no_auto_load`=0, a down step that lands on 000000 reloads `preset_val` and raises `zero_flag` for exactly one clock.
- R10: With `no_auto_load`=1, a down step to zero leaves the count at 000000 until a load or a further step.
- R11: A step that lands on `presig_val` raises `presig_flag`. The flag stays high until the next step, `clr` or `load`.
- R12: `zero_flag` is high in every cycle in which `count_o` is 000000.
- R13: After `rst`, `count_o`=000000, `zero_flag`=1, and `main_flag` and `presig_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_in | input | 1 | Asynchronous count strobe; steps on its rising edge |
| up_dn | input | 1 | 1 = count up, 0 = count down |
| cnt_hold | input | 1 | Count inhibit |
| clr | input | 1 | Manual clear to zero |
| load | input | 1 | Manual load from preset store |
| div_sel | input | 2 | Prescaler select (see R3) |
| no_auto_clr | input | 1 | Disables automatic clear on main-signal match |
| no_auto_load | input | 1 | Disables automatic reload on reaching zero |
| preset_val | input | 24 | Preset store, six BCD digits |
| presig_val | input | 24 | Presignal store, six BCD digits |
| main_val | input | 24 | Main-signal store, six BCD digits |
| count_o | output | 24 | Registered BCD count |
| main_flag | output | 1 | Main-signal comparator flag |
| presig_flag | output | 1 | Presignal comparator flag |
| zero_flag | output | 1 | Zero-detect flag |

## Verification
The bench targets carry and borrow ripple across several digits, including the full wrap in both directions. A design that got this wrong would show hex digits or skip a decade. It checks the prescaler edge: the fifth or sixth strobe must produce the step and the one before it must not, so an off-by-one divider fails. It measures the width of the automatic main-signal and zero flags in clock cycles and checks that the manual-mode flags stay up. This exposes a design whose flags stick in automatic mode or vanish in manual mode. It also drives clear, load and inhibit together to catch a wrong priority order.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

  typedef enum logic [1:0] {
    DIV_BY5 = 2'b00,
    DIV_BY6 = 2'b01,
    DIV_BY1 = 2'b11
  } div_mode_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/div_prescaler.sv
module div_prescaler
  import bcd_pkg::*;
#(
  parameter int MAX_DIV = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       ev_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int CW = $clog2(MAX_DIV);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] last_c;
  logic          bypass_c;

  always_comb begin
    bypass_c = 1'b0;
    last_c   = '0;
    case (sel_i)
      DIV_BY5: last_c   = CW'(4);
      DIV_BY6: last_c   = CW'(5);
      default: bypass_c = 1'b1;
    endcase
  end

  assign tick_o = ev_i & (bypass_c | (phase_q == last_c));

  always_ff @(posedge clk) begin
    if (rst || restart)  phase_q <= '0;
    else if (ev_i) begin
      if (tick_o)        phase_q <= '0;
      else               phase_q <= phase_q + CW'(1);
    end
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_pkg::*;
(
  input  logic [DIG_W-1:0] d_i,
  input  logic             up_i,
  input  logic             cin_i,
  output logic [DIG_W-1:0] d_o,
  output logic             cout_o
);
  always_comb begin
    d_o    = d_i;
    cout_o = 1'b0;
    if (cin_i) begin
      if (up_i) begin
        if (d_i >= DIG_MAX) begin d_o = '0; cout_o = 1'b1; end
        else                     d_o = d_i + DIG_W'(1);
      end else begin
        if (d_i == '0) begin d_o = DIG_MAX; cout_o = 1'b1; end
        else                 d_o = d_i - DIG_W'(1);
      end
    end
  end
endmodule

// File: rtl/bcd_stepper.sv
module bcd_stepper
  import bcd_pkg::*;
#(
  parameter int NDIG = 6
) (
  input  logic [NDIG*DIG_W-1:0] val_i,
  input  logic                  up_i,
  output logic [NDIG*DIG_W-1:0] val_o
);
  logic [NDIG:0] chain;
  assign chain[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit u_dig (
      .d_i   (val_i[g*DIG_W +: DIG_W]),
      .up_i  (up_i),
      .cin_i (chain[g]),
      .d_o   (val_o[g*DIG_W +: DIG_W]),
      .cout_o(chain[g+1])
    );
  end
endmodule

// File: rtl/bcd_predet_counter.sv
module bcd_predet_counter
  import bcd_pkg::*;
#(
  parameter int NDIG        = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_DIV     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_in,
  input  logic                  up_dn,
  input  logic                  cnt_hold,
  input  logic                  clr,
  input  logic                  load,
  input  logic [1:0]            div_sel,
  input  logic                  no_auto_clr,
  input  logic                  no_auto_load,
  input  logic [NDIG*DIG_W-1:0] preset_val,
  input  logic [NDIG*DIG_W-1:0] presig_val,
  input  logic [NDIG*DIG_W-1:0] main_val,
  output logic [NDIG*DIG_W-1:0] count_o,
  output logic                  main_flag,
  output logic                  presig_flag,
  output logic                  zero_flag
);
  localparam int W = NDIG * DIG_W;

  logic         rise_w, qual_w, step_w;
  logic [W-1:0] next_w;
  logic [W-1:0] count_q, count_d;
  logic         main_q, main_d, hold_main_q, hold_main_d;
  logic         pre_q, pre_d, zero_q, zero_d, zpulse_c;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(cnt_in),
    .rise_o  (rise_w)
  );

  assign qual_w = rise_w & ~cnt_hold & ~clr & ~load;

  div_prescaler #(.MAX_DIV(MAX_DIV)) u_div (
    .clk    (clk),
    .rst    (rst),
    .restart(clr | load),
    .ev_i   (qual_w),
    .sel_i  (div_sel),
    .tick_o (step_w)
  );

  bcd_stepper #(.NDIG(NDIG)) u_step (
    .val_i(count_q),
    .up_i (up_dn),
    .val_o(next_w)
  );

  always_comb begin
    count_d     = count_q;
    main_d      = main_q & hold_main_q;
    hold_main_d = hold_main_q;
    pre_d       = pre_q;
    zpulse_c    = 1'b0;
    if (clr) begin
      count_d     = '0;
      main_d      = 1'b0;
      hold_main_d = 1'b0;
      pre_d       = 1'b0;
    end else if (load) begin
      count_d = preset_val;
      pre_d   = 1'b0;
    end else if (step_w) begin
      count_d     = next_w;
      main_d      = 1'b0;
      hold_main_d = 1'b0;
      pre_d       = (next_w == presig_val);
      if (next_w == main_val) begin
        main_d = 1'b1;
        if (up_dn && !no_auto_clr) count_d     = '0;
        else                       hold_main_d = 1'b1;
      end
      if (!up_dn && !no_auto_load && next_w == '0) begin
        count_d  = preset_val;
        zpulse_c = 1'b1;
      end
    end
    zero_d = (count_d == '0) | zpulse_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '0;
      main_q      <= 1'b0;
      hold_main_q <= 1'b0;
      pre_q       <= 1'b0;
      zero_q      <= 1'b1;
    end else begin
      count_q     <= count_d;
      main_q      <= main_d;
      hold_main_q <= hold_main_d;
      pre_q       <= pre_d;
      zero_q      <= zero_d;
    end
  end

  assign count_o     = count_q;
  assign main_flag   = main_q;
  assign presig_flag = pre_q;
  assign zero_flag   = zero_q;
endmodule

// File: rtl/bcd_predet_counter_chk.sv
module bcd_predet_counter_chk
  import bcd_pkg::*;
#(
  parameter int NDIG = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cnt_hold,
  input logic                  clr,
  input logic                  load,
  input logic [NDIG*DIG_W-1:0] preset_val,
  input logic [NDIG*DIG_W-1:0] count_o,
  input logic                  main_flag,
  input logic                  presig_flag,
  input logic                  zero_flag
);
  for (genvar g = 0; g < NDIG; g++) begin : g_rng
    a_r1_digit_range: assert property (@(posedge clk) disable iff (rst)
      count_o[g*DIG_W +: DIG_W] <= DIG_MAX);
  end

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_o == '0) && !main_flag && !presig_flag);

  a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (count_o == $past(preset_val)) && !presig_flag);

  a_r4_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (cnt_hold && !clr && !load) |=> $stable(count_o));

  a_r12_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0) |-> zero_flag);
endmodule

bind bcd_predet_counter bcd_predet_counter_chk #(.NDIG(NDIG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_hold   (cnt_hold),
  .clr        (clr),
  .load       (load),
  .preset_val (preset_val),
  .count_o    (count_o),
  .main_flag  (main_flag),
  .presig_flag(presig_flag),
  .zero_flag  (zero_flag)
);

// File: tb/bcd_predet_counter_test.sv
module bcd_predet_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_in = 1'b0, up_dn = 1'b1, cnt_hold = 1'b0, clr = 1'b0, load = 1'b0;
  logic [1:0]  div_sel = 2'b11;
  logic        no_auto_clr = 1'b1, no_auto_load = 1'b1;
  logic [23:0] preset_val = '0, presig_val = 24'h123456, main_val = 24'h500000;
  logic [23:0] count_o;
  logic        main_flag, presig_flag, zero_flag;

  int tests = 0, fails = 0;
  int mcyc = 0, zcyc = 0, base;

  always #10 clk = ~clk;

  bcd_predet_counter uut (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .up_dn(up_dn), .cnt_hold(cnt_hold),
    .clr(clr), .load(load), .div_sel(div_sel), .no_auto_clr(no_auto_clr),
    .no_auto_load(no_auto_load), .preset_val(preset_val), .presig_val(presig_val),
    .main_val(main_val), .count_o(count_o), .main_flag(main_flag),
    .presig_flag(presig_flag), .zero_flag(zero_flag)
  );

  always @(negedge clk) begin
    if (main_flag) mcyc++;
    if (zero_flag) zcyc++;
  end

  // {preset[52:29], up[28], strobes[27:24], expected[23:0]}
  localparam logic [52:0] TBL [8] = '{
    {24'h000000, 1'b1, 4'd3, 24'h000003},
    {24'h000009, 1'b1, 4'd1, 24'h000010},
    {24'h099999, 1'b1, 4'd1, 24'h100000},
    {24'h000010, 1'b0, 4'd1, 24'h000009},
    {24'h100000, 1'b0, 4'd1, 24'h099999},
    {24'h000005, 1'b0, 4'd2, 24'h000003},
    {24'h999999, 1'b1, 4'd1, 24'h000000},
    {24'h000002, 1'b0, 4'd3, 24'h999999}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_in = 1'b1;
      repeat (4) @(negedge clk);
      cnt_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic do_load(input logic [23:0] v);
    preset_val = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 count", count_o, 24'h0);
    chk("R13 zero_flag", {23'd0, zero_flag}, 24'd1);
    chk("R13 main/presig", {22'd0, main_flag, presig_flag}, 24'd0);

    // vector table: R1 R2 R10
    for (int k = 0; k < 8; k++) begin
      do_load(TBL[k][52:29]);
      up_dn = TBL[k][28];
      strobe(int'(TBL[k][27:24]));
      chk($sformatf("R1/R2 vector %0d", k), count_o, TBL[k][23:0]);
    end
    chk("R12 zero after wrap", {23'd0, zero_flag}, 24'd0);

    // R10: manual mode stays at zero
    up_dn = 1'b0;
    do_load(24'h000001);
    strobe(1);
    chk("R10 stays zero", count_o, 24'h0);
    chk("R12 zero flag high", {23'd0, zero_flag}, 24'd1);

    // R3 prescaler
    up_dn = 1'b1;
    div_sel = 2'b00;
    do_load(24'h0);
    strobe(4);
    chk("R3 div5 before", count_o, 24'h0);
    strobe(1);
    chk("R3 div5 step", count_o, 24'h1);
    div_sel = 2'b01;
    do_load(24'h0);
    strobe(5);
    chk("R3 div6 before", count_o, 24'h0);
    strobe(1);
    chk("R3 div6 step", count_o, 24'h1);
    div_sel = 2'b11;

    // R4 hold, R6 load beats hold
    do_load(24'h000042);
    cnt_hold = 1'b1;
    strobe(2);
    chk("R4 hold frozen", count_o, 24'h000042);
    do_load(24'h000321);
    chk("R6 load during hold", count_o, 24'h000321);
    cnt_hold = 1'b0;
    strobe(1);
    chk("R4 released", count_o, 24'h000322);

    // R5 clear beats load
    preset_val = 24'h000077;
    clr = 1'b1; load = 1'b1;
    @(negedge clk);
    clr = 1'b0; load = 1'b0;
    @(negedge clk);
    chk("R5 clear wins", count_o, 24'h0);

    // R7 auto clear
    main_val = 24'h000005;
    no_auto_clr = 1'b0;
    do_load(24'h000003);
    base = mcyc;
    strobe(2);
    chk("R7 count cleared", count_o, 24'h0);
    chk("R7 pulse width", 24'(mcyc - base), 24'd1);

    // R8 manual main
    no_auto_clr = 1'b1;
    do_load(24'h000003);
    strobe(2);
    chk("R8 count held", count_o, 24'h000005);
    chk("R8 flag held", {23'd0, main_flag}, 24'd1);
    strobe(1);
    chk("R8 flag drops on step", {23'd0, main_flag}, 24'd0);
    main_val = 24'h500000;

    // R9 auto reload
    up_dn = 1'b0;
    no_auto_load = 1'b0;
    do_load(24'h000001);
    preset_val = 24'h000004;
    base = zcyc;
    strobe(1);
    chk("R9 reload", count_o, 24'h000004);
    chk("R9 pulse width", 24'(zcyc - base), 24'd1);
    no_auto_load = 1'b1;

    // R11 presignal
    up_dn = 1'b1;
    presig_val = 24'h000007;
    do_load(24'h000006);
    strobe(1);
    chk("R11 flag set", {23'd0, presig_flag}, 24'd1);
    do_load(24'h000006);
    chk("R11 load clears", {23'd0, presig_flag}, 24'd0);
    strobe(1);
    strobe(1);
    chk("R11 step clears", {23'd0, presig_flag}, 24'd0);
    chk("R2 count after", count_o, 24'h000008);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule